// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block holds several independent 32-bit down counters behind a small register bus. Software loads an interval value, then sets a channel's control word to start it. The channel loads the interval into its counter and counts down on a tick input. The tick stands in for the selected source clock. A per-channel power-of-two divider can slow the tick. When a counter reaches zero, the channel latches a pending bit. In periodic mode the channel reloads and keeps running. In one-shot mode it disarms itself.

One interrupt line is raised while any channel has a pending bit and also has its interrupt enabled. Software clears a pending bit by writing a one to it. The run bit passes through a two-stage pipeline that advances on the tick. Because of this, starting and stopping both take effect two source ticks after the write. Software has to allow for that latency before it reprograms a stopped channel.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every readable register returns zero and `irq` is low.
- R2: Register map. The interrupt enable register is at 0x00, with bit n enabling channel n. Pending status is at 0x04, bit n for channel n. Channel n has its control word at 0x10+0x10*n, its interval at 0x14+0x10*n and its read-only count at 0x18+0x10*n. Control bits are: run = bit 0, reload = bit 1, source = bits 3:2, divider = bits 6:4, one-shot = bit 7. The source field is stored and read back but has no effect on counting. Writes to a count register or to an unmapped address change nothing, and unmapped addresses read zero.
- R3: With run and reload written together, the run bit takes effect after two `tick_en` cycles. The counter takes the interval value on the third tick, and the reload bit then reads back as zero.
- R4: A running counter falls by one on each divided tick. Without `tick_en`, no count changes.
- R5: With divider field d, a running counter falls once per 2^d ticks, counted from the tick that loaded it.
- R6: A step that takes the count from 1 to 0 sets the channel's pending bit. In periodic mode (bit 7 clear), the next divided tick loads the interval and counting carries on.
- R7: In one-shot mode, expiry clears the run bit in hardware, and the count stays at 0.
- R8: After software clears the run bit, a channel with divider 0 counts on exactly two more ticks and then holds its value.
- R9: Writing 1 to a pending bit clears it. Writing 0 leaves it as it is. An expiry in the same cycle as a clear leaves the bit set.
- R10: `irq` is a register that equals, one cycle later, the OR over channels of pending AND enable.
- R11: An interval of all ones loads 0xFFFFFFFF and counts down from there as a free-running 32-bit counter.
- R12: Channels run independently. Programming or running one channel does not change another's count or pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle tick of the selected source clock |
| bus_addr | input | AW (8) | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Read data, registered one cycle after the address |
| irq | output | 1 | Registered combined interrupt |

## Verification
A fault in the run pipeline or the divider shows up as a count that moves one tick early or late. With the tick held low, the count can be read back as an exact value right after each single tick. The tests therefore step the source one tick at a time and compare the count after every tick. A fault in pending or enable state appears on `irq` one cycle after the edge that caused it. A fault in the one-shot or reload self-clearing appears in the control word readback on the next read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Control word layout, bit 0 first from the right.
  typedef struct packed {
    logic       one_shot;
    logic [2:0] div_sel;
    logic [1:0] src_sel;
    logic       reload;
    logic       run;
  } tmr_ctrl_t;

  localparam int CTRL_W    = $bits(tmr_ctrl_t);
  localparam int ADDR_IEN  = 'h00;
  localparam int ADDR_STS  = 'h04;
  localparam int CH_BASE   = 'h10;
  localparam int CH_STRIDE = 'h10;
  localparam int OFS_CTRL  = 'h0;
  localparam int OFS_IVAL  = 'h4;
  localparam int OFS_CNT   = 'h8;
  localparam int RUN_STAGES = 2;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)       sh <= '0;
    else if (tick) sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clear,
  input  logic [DIV_W-1:0] div_sel,
  output logic             ptick
);
  localparam int PW = (1 << DIV_W) - 1;

  logic [PW-1:0] pcnt;
  logic [PW:0]   one_hot;
  logic [PW-1:0] mask;

  always_comb begin
    one_hot = (PW+1)'(1) << div_sel;
    mask    = PW'(one_hot - (PW+1)'(1));
  end

  assign ptick = tick && (pcnt == mask);

  always_ff @(posedge clk) begin
    if (rst || clear) pcnt <= '0;
    else if (tick)    pcnt <= ptick ? '0 : pcnt + PW'(1);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW    = 32,
  parameter int DIV_W = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ctrl_we,
  input  logic          ival_we,
  input  logic [CW-1:0] wdata,
  output tmr_ctrl_t     ctrl,
  output logic [CW-1:0] ival,
  output logic [CW-1:0] count,
  output logic          expire
);
  logic running, load_now, ptick, step, at_zero;

  tmr_sync #(.STAGES(RUN_STAGES)) u_sync (
    .clk(clk), .rst(rst), .tick(tick), .d(ctrl.run), .q(running)
  );

  assign load_now = running && tick && ctrl.reload;

  tmr_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .tick(tick),
    .clear(!running || load_now),
    .div_sel(DIV_W'(ctrl.div_sel)),
    .ptick(ptick)
  );

  assign step    = running && ptick && !ctrl.reload;
  assign at_zero = (count == '0);
  assign expire  = step && (count == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load_now) begin
      count <= ival;
    end else if (step) begin
      if (at_zero) begin
        if (!ctrl.one_shot) count <= ival;
      end else begin
        count <= count - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (ctrl_we) begin
      ctrl <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
    end else begin
      if (load_now)                 ctrl.reload <= 1'b0;
      if (expire && ctrl.one_shot)  ctrl.run    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ival <= '0;
    else if (ival_we) ival <= wdata;
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CW    = 32,
  parameter int AW    = 8,
  parameter int DIV_W = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);
  function automatic logic [AW-1:0] ch_addr(int ch, int ofs);
    return AW'(CH_BASE + CH_STRIDE * ch + ofs);
  endfunction

  logic [NCH-1:0]    ien_q, sts_q, expire, w1c;
  logic [NCH-1:0]    run_v, one_shot_v, reload_v;
  logic [NCH*CW-1:0] cnt_flat;
  tmr_ctrl_t         ctrl_a [NCH];
  logic [CW-1:0]     ival_a [NCH];
  logic [CW-1:0]     cnt_a  [NCH];
  logic [CW-1:0]     rd_next;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tmr_channel #(.CW(CW), .DIV_W(DIV_W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick_en),
      .ctrl_we(bus_we && bus_addr == ch_addr(ch, OFS_CTRL)),
      .ival_we(bus_we && bus_addr == ch_addr(ch, OFS_IVAL)),
      .wdata(bus_wdata),
      .ctrl(ctrl_a[ch]), .ival(ival_a[ch]), .count(cnt_a[ch]),
      .expire(expire[ch])
    );
    assign run_v[ch]      = ctrl_a[ch].run;
    assign one_shot_v[ch] = ctrl_a[ch].one_shot;
    assign reload_v[ch]   = ctrl_a[ch].reload;
    assign cnt_flat[ch*CW +: CW] = cnt_a[ch];
  end

  assign w1c = (bus_we && bus_addr == AW'(ADDR_STS)) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= '0;
      sts_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (bus_we && bus_addr == AW'(ADDR_IEN)) ien_q <= bus_wdata[NCH-1:0];
      sts_q <= (sts_q & ~w1c) | expire;
      irq   <= |(sts_q & ien_q);
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == AW'(ADDR_IEN)) rd_next = CW'(ien_q);
    if (bus_addr == AW'(ADDR_STS)) rd_next = CW'(sts_q);
    for (int ch = 0; ch < NCH; ch++) begin
      if (bus_addr == ch_addr(ch, OFS_CTRL)) rd_next = CW'(ctrl_a[ch]);
      if (bus_addr == ch_addr(ch, OFS_IVAL)) rd_next = ival_a[ch];
      if (bus_addr == ch_addr(ch, OFS_CNT))  rd_next = cnt_a[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int NCH = 2,
  parameter int CW  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              bus_we,
  input logic              irq,
  input logic [NCH-1:0]    ien,
  input logic [NCH-1:0]    sts,
  input logic [NCH-1:0]    run_v,
  input logic [NCH-1:0]    one_shot_v,
  input logic [NCH-1:0]    reload_v,
  input logic [NCH*CW-1:0] cnt_flat
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
      !tick_en |=> $stable(cnt_flat[ch*CW +: CW]));
    a_r6_pending_on_tick: assert property (@(posedge clk) disable iff (rst)
      $rose(sts[ch]) |-> $past(tick_en));
    a_r7_oneshot_disarms: assert property (@(posedge clk) disable iff (rst)
      ($rose(sts[ch]) && one_shot_v[ch] && !$past(bus_we)) |-> !run_v[ch]);
    a_r3_reload_clears_on_tick: assert property (@(posedge clk) disable iff (rst)
      $fell(reload_v[ch]) |-> ($past(tick_en) || $past(bus_we)));
  end

  a_r10_irq_needs_enabled_pending: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(sts & ien)));
endmodule

bind tick_timer_bank tmr_checker #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .bus_we(bus_we), .irq(irq),
  .ien(ien_q), .sts(sts_q), .run_v(run_v), .one_shot_v(one_shot_v),
  .reload_v(reload_v), .cnt_flat(cnt_flat)
);

// File: tb/tick_timer_bank_tb.sv
`timescale 1ns/1ps
module tick_timer_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  tick_timer_bank u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] a_ctl(int ch); return 8'(16 + 16*ch); endfunction
  function automatic logic [7:0] a_ivl(int ch); return 8'(20 + 16*ch); endfunction
  function automatic logic [7:0] a_cnt(int ch); return 8'(24 + 16*ch); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic wr_tick(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_en = 1'b1;
    @(posedge clk); @(negedge clk); bus_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(posedge clk); @(negedge clk); d = bus_rdata;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(posedge clk); @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic stop_ch(int ch);
    wr(a_ctl(ch), 32'h0);
    pulse(3);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    rd(8'h00, d); chk("R1 ien", d, 0);
    rd(8'h04, d); chk("R1 sts", d, 0);
    rd(a_ctl(0), d); chk("R1 ctrl0", d, 0);
    rd(a_ivl(1), d); chk("R1 ival1", d, 0);
    rd(a_cnt(0), d); chk("R1 cnt0", d, 0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); chk("R2 unmapped", d, 0);
    wr(a_ivl(0), 32'h55); rd(a_ivl(0), d); chk("R2 ival", d, 32'h55);
    wr(a_cnt(0), 32'h1234); rd(a_cnt(0), d); chk("R2 count ro", d, 0);
    wr(8'h00, 32'hFF); rd(8'h00, d); chk("R2 ien width", d, 32'h3);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_start;
    logic [31:0] d;
    wr(a_ivl(0), 5);
    wr(a_ctl(0), 32'h07);
    pulse(1); rd(a_cnt(0), d); chk("R3 sync1", d, 0);
    pulse(1); rd(a_cnt(0), d); chk("R3 sync2", d, 0);
    pulse(1); rd(a_cnt(0), d); chk("R3 load", d, 5);
    rd(a_ctl(0), d); chk("R3 reload clears, R2 src kept", d, 32'h05);
    pulse(1); rd(a_cnt(0), d); chk("R4 step", d, 4);
    rd(a_cnt(0), d); chk("R4 hold no tick", d, 4);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    pulse(1);
    wr(a_ctl(0), 32'h04);
    pulse(1); rd(a_cnt(0), d); chk("R8 tick1", d, 2);
    pulse(1); rd(a_cnt(0), d); chk("R8 tick2", d, 1);
    pulse(3); rd(a_cnt(0), d); chk("R8 frozen", d, 1);
    rd(8'h04, d); chk("R8 no pending", d, 0);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    wr(a_ivl(0), 10);
    wr(a_ctl(0), 32'h23);
    pulse(3); rd(a_cnt(0), d); chk("R5 load", d, 10);
    pulse(3); rd(a_cnt(0), d); chk("R5 div wait", d, 10);
    pulse(1); rd(a_cnt(0), d); chk("R5 4th tick", d, 9);
    pulse(4); rd(a_cnt(0), d); chk("R5 next 4", d, 8);
    stop_ch(0);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    wr(8'h04, 3); wr(8'h00, 1);
    wr(a_ivl(0), 2); wr(a_ctl(0), 32'h03);
    pulse(3); rd(a_cnt(0), d); chk("R6 load", d, 2);
    pulse(1); rd(8'h04, d); chk("R6 no pending at 1", d, 0);
    pulse(1);
    chk("R10 irq latency", {31'b0, irq}, 0);
    rd(a_cnt(0), d); chk("R6 zero", d, 0);
    chk("R10 irq up", {31'b0, irq}, 1);
    rd(8'h04, d); chk("R6 pending", d, 1);
    pulse(1); rd(a_cnt(0), d); chk("R6 reload", d, 2);
    wr(8'h04, 0); rd(8'h04, d); chk("R9 write 0", d, 1);
    wr(8'h04, 2); rd(8'h04, d); chk("R9 other bit", d, 1);
    wr(8'h04, 1); rd(8'h04, d); chk("R9 clear", d, 0);
    chk("R10 irq down", {31'b0, irq}, 0);
    pulse(1);
    wr_tick(8'h04, 1);
    rd(a_cnt(0), d); chk("R9 count", d, 0);
    rd(8'h04, d); chk("R9 set wins", d, 1);
    wr(8'h00, 0); rd(8'h00, d);
    chk("R10 gated", {31'b0, irq}, 0);
    stop_ch(0); wr(8'h04, 3);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    wr(a_ivl(0), 3); wr(a_ctl(0), 32'h83);
    pulse(3); rd(a_cnt(0), d); chk("R7 load", d, 3);
    pulse(3); rd(a_cnt(0), d); chk("R7 zero", d, 0);
    rd(8'h04, d); chk("R7 pending", d, 1);
    rd(a_ctl(0), d); chk("R7 run cleared", d, 32'h80);
    pulse(4); rd(a_cnt(0), d); chk("R7 holds 0", d, 0);
    wr(8'h04, 3);
  endtask

  task automatic t_freerun;
    logic [31:0] d;
    wr(a_ivl(1), 32'hFFFF_FFFF); wr(a_ctl(1), 32'h03);
    pulse(3); rd(a_cnt(1), d); chk("R11 load ones", d, 32'hFFFF_FFFF);
    pulse(1); rd(a_cnt(1), d); chk("R11 step", d, 32'hFFFF_FFFE);
    rd(a_cnt(0), d); chk("R12 ch0 untouched", d, 0);
    rd(8'h04, d); chk("R12 no pending", d, 0);
    wr(a_ivl(0), 5); wr(a_ctl(0), 32'h03);
    pulse(3);
    rd(a_cnt(0), d); chk("R12 ch0 load", d, 5);
    rd(a_cnt(1), d); chk("R12 ch1 continues", d, 32'hFFFF_FFFB);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_map();
    t_start();
    t_stop();
    t_prescale();
    t_periodic();
    stop_ch(0);
    t_oneshot();
    t_freerun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule